// File: doc/BRIEF.md
# Pixel Colour Matrix Stage

This block sits in a display pixel pipeline between the frame composer and the link encoder. Each pixel of three 8-bit components is multiplied by a programmable 3x3 fixed-point gain matrix. A per-row offset is added, and the result is rounded and clamped back to 8 bits. A typical use is squeezing full-range RGB (0..255) into the limited video range (16..235). To do this, a gain of roughly 0.86 is placed on the anti-diagonal and an offset of 16 levels is placed on each row. The anti-diagonal placement also swaps the outer components.

Software programs a control register and six coefficient registers through a simple write port. Each coefficient register holds two 16-bit terms. Writes land in shadow copies. They become active only on a frame-start strobe, so every frame is processed with one consistent setting. When the matrix is off, or a table mode other than the custom one is chosen, pixels pass through unchanged apart from the optional component swap. The latency in that case is the same as in matrix mode.

Top module: `pix_matrix_xform`

## Requirements
- R1: After reset the outputs `out_valid`, `out_sync` and `out_ycc` are 0, the active control is cleared (bypass, no swap) and all coefficients and offsets are zero. Enabling the custom matrix without loading coefficients therefore yields 0 on every component.
- R2: The control register is at address 0x40. Its fields are: bit 0 is the matrix enable, bit 1 is a colour-difference flag, bits 3:2 are the mode and bit 4 is the swap select. The flag bit does not change the arithmetic. Its active value appears on `out_ycc`.
- R3: The matrix is applied only when the enable bit is 1 and the mode is 3. Any other combination, including modes 0 and 1, passes the components through unchanged.
- R4: When bit 4 is 1, components 0 and 2 of the input are exchanged before the matrix stage. This exchange happens in bypass as well as in matrix mode. Component 0 is `in_pix[7:0]`, component 1 is `in_pix[15:8]` and component 2 is `in_pix[23:16]`. `out_pix` uses the same layout.
- R5: Output row r (r = 0..2) is set by two registers. Register 0x44+8r holds the column-0 gain in bits 15:0 and the column-1 gain in bits 31:16. Register 0x48+8r holds the column-2 gain in bits 15:0 and the row offset in bits 31:16. The column-j gain multiplies (possibly swapped) input component j, and row r drives output component r.
- R6: Gains are signed 16-bit values with 11 fraction bits, so 0x800 is unity. Offsets are signed with 4 fraction bits. Each output equals floor((sum of the three products x 2048-scaled + offset x 128 + 1024) / 2048), which rounds halves upward.
- R7: Results below 0 clamp to 0 and results above 255 clamp to 255.
- R8: Data, `out_valid` and `out_sync` follow the input exactly 3 clock cycles later, in both bypass and matrix mode.
- R9: Register writes do not affect the output until `frame_start` is pulsed. A pulse activates the shadow contents.
- R10: With gain 0x6E0 on the anti-diagonal and offset 0x100 on every row, input 0 maps to 16 and input 255 maps to 235.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Activates shadow settings |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel, three 8-bit components |
| in_sync | input | 2 | Sideband delayed with the pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output pixel |
| out_sync | output | 2 | Delayed sideband |
| out_ycc | output | 1 | Active colour-difference flag |

## Verification
The arithmetic is tried with several matrices. An identity matrix shows the gain scaling and the column-to-row wiring. A mixed matrix with distinct terms in every position reveals any swapped register halves or rows. The limited-range anti-diagonal matrix hits the 16 and 235 endpoints. Half-step gains and offsets separate round-half-up from truncation, and over- and under-range matrices exercise both clamp limits. Bypass is tried with zero coefficients and non-custom modes, so that a wrongly applied matrix shows up as zeros. Writes made between strobes confirm that the old setting stays active until the next frame start.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
    localparam int PIX_W      = 8;
    localparam int NCOMP      = 3;
    localparam int COEF_W     = 16;
    localparam int FRAC_W     = 11;
    localparam int OFF_FRAC_W = 4;
    localparam int OFF_SH     = FRAC_W - OFF_FRAC_W;
    localparam int ACC_W      = COEF_W + PIX_W + 4;
    localparam int ADDR_W     = 8;
    localparam int REG_W      = 2 * COEF_W;
    localparam int SB_W       = 2;
    localparam int LAT        = 3;

    localparam logic [1:0] MODE_CUSTOM = 2'd3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 8'h40,
        ADDR_COEF0 = 8'h44
    } reg_addr_e;

    typedef logic [PIX_W-1:0]         comp_t;
    typedef comp_t [NCOMP-1:0]        pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        logic       swap;
        logic [1:0] mode;
        logic       ycc;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        coef_t                off;
        coef_t [NCOMP-1:0]    k;
    } row_t;

    localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] SAT_MAX  = ACC_W'((1 << PIX_W) - 1);

    function automatic pix_t swap_ends(input pix_t p, input logic en);
        pix_t r;
        for (int i = 0; i < NCOMP; i++)
            r[i] = en ? p[NCOMP-1-i] : p[i];
        return r;
    endfunction

    function automatic comp_t sat_round(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] t;
        t = (a + RND_HALF) >>> FRAC_W;
        if (t < 0)
            return '0;
        else if (t > SAT_MAX)
            return '1;
        else
            return t[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/pxm_cfg.sv
module pxm_cfg
    import pxm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  frame_start,
    output ctrl_t                 act_ctrl,
    output row_t [NCOMP-1:0]      act_rows
);
    ctrl_t            sh_ctrl;
    row_t [NCOMP-1:0] sh_rows;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ctrl <= '0;
            sh_rows <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)
                sh_ctrl <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
            for (int r = 0; r < NCOMP; r++) begin
                if (wr_addr == ADDR_W'(ADDR_COEF0 + 8 * r)) begin
                    sh_rows[r].k[0] <= wr_data[COEF_W-1:0];
                    sh_rows[r].k[1] <= wr_data[REG_W-1:COEF_W];
                end
                if (wr_addr == ADDR_W'(ADDR_COEF0 + 8 * r + 4)) begin
                    sh_rows[r].k[2] <= wr_data[COEF_W-1:0];
                    sh_rows[r].off  <= wr_data[REG_W-1:COEF_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctrl <= '0;
            act_rows <= '0;
        end else if (frame_start) begin
            act_ctrl <= sh_ctrl;
            act_rows <= sh_rows;
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(act_ctrl) && $stable(act_rows))); // R9
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (act_ctrl == $past(sh_ctrl))); // R9
endmodule

// File: rtl/pxm_lane.sv
module pxm_lane
    import pxm_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  pix_t  x,
    input  logic  byp,
    input  row_t  row,
    output comp_t y
);
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_q;
    comp_t                   pass_q;
    logic                    byp_q;

    always_comb begin
        sum = ACC_W'(signed'(row.off)) <<< OFF_SH;
        for (int j = 0; j < NCOMP; j++)
            sum += ACC_W'(signed'(row.k[j])) * ACC_W'(signed'({1'b0, x[j]}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pass_q <= '0;
            byp_q  <= 1'b1;
            y      <= '0;
        end else begin
            acc_q  <= sum;
            pass_q <= x[LANE];
            byp_q  <= byp;
            y      <= byp_q ? pass_q : sat_round(acc_q);
        end
    end
endmodule

// File: rtl/pix_matrix_xform.sv
module pix_matrix_xform
    import pxm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      frame_start,
    input  logic                      in_valid,
    input  logic [NCOMP*PIX_W-1:0]    in_pix,
    input  logic [SB_W-1:0]           in_sync,
    output logic                      out_valid,
    output logic [NCOMP*PIX_W-1:0]    out_pix,
    output logic [SB_W-1:0]           out_sync,
    output logic                      out_ycc
);
    ctrl_t            act_ctrl;
    row_t [NCOMP-1:0] act_rows;
    pix_t             x_q;
    logic             byp_q;
    logic [LAT-1:0]   vld_pipe;
    logic [SB_W-1:0]  sb_pipe [LAT];
    pix_t             y;

    pxm_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .act_ctrl    (act_ctrl),
        .act_rows    (act_rows)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            byp_q <= 1'b1;
        end else begin
            x_q   <= swap_ends(pix_t'(in_pix), act_ctrl.swap);
            byp_q <= !(act_ctrl.enable && act_ctrl.mode == MODE_CUSTOM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe <= '0;
            for (int i = 0; i < LAT; i++) sb_pipe[i] <= '0;
        end else begin
            vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
            sb_pipe[0] <= in_sync;
            for (int i = 1; i < LAT; i++) sb_pipe[i] <= sb_pipe[i-1];
        end
    end

    for (genvar g = 0; g < NCOMP; g++) begin : g_lane
        pxm_lane #(.LANE(g)) u_lane (
            .clk (clk),
            .rst (rst),
            .x   (x_q),
            .byp (byp_q),
            .row (act_rows[g]),
            .y   (y[g])
        );
    end

    assign out_pix   = y;
    assign out_valid = vld_pipe[LAT-1];
    assign out_sync  = sb_pipe[LAT-1];
    assign out_ycc   = act_ctrl.ycc;

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R8
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_sync == $past(in_sync, 3))); // R8
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sync == '0 && !out_ycc)); // R1
endmodule

// File: tb/pix_matrix_xform_tb.sv
module pix_matrix_xform_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pix = '0;
    logic [1:0]  in_sync = '0;
    logic        out_valid;
    logic [23:0] out_pix;
    logic [1:0]  out_sync;
    logic        out_ycc;

    int checks = 0;
    int errors = 0;
    int kc [3][4];
    logic swap_cfg = 1'b0;
    logic mat_cfg  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pix_matrix_xform u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start), .in_valid(in_valid), .in_pix(in_pix),
        .in_sync(in_sync), .out_valid(out_valid), .out_pix(out_pix),
        .out_sync(out_sync), .out_ycc(out_ycc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic set_row(input int r, input int a, input int b, input int c, input int o);
        kc[r][0] = a; kc[r][1] = b; kc[r][2] = c; kc[r][3] = o;
    endtask

    task automatic write_matrix();
        for (int r = 0; r < 3; r++) begin
            wr(8'h44 + 8'(8 * r), {kc[r][1][15:0], kc[r][0][15:0]});
            wr(8'h48 + 8'(8 * r), {kc[r][3][15:0], kc[r][2][15:0]});
        end
    endtask

    function automatic int model(input int r, input int x0, input int x1, input int x2);
        int s, q;
        s = kc[r][0] * x0 + kc[r][1] * x1 + kc[r][2] * x2 + kc[r][3] * 128;
        q = (s + 1024) >>> 11;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    // Drive one pixel, then check latency and the expected components.
    task automatic push(input int c0, input int c1, input int c2, input logic [1:0] sb,
                        input string req);
        int x0, x1, x2, e0, e1, e2;
        x0 = swap_cfg ? c2 : c0;
        x1 = c1;
        x2 = swap_cfg ? c0 : c2;
        if (mat_cfg) begin
            e0 = model(0, x0, x1, x2); e1 = model(1, x0, x1, x2); e2 = model(2, x0, x1, x2);
        end else begin
            e0 = x0; e1 = x1; e2 = x2;
        end
        @(negedge clk);
        in_valid = 1'b1; in_pix = {c2[7:0], c1[7:0], c0[7:0]}; in_sync = sb;
        @(negedge clk);
        in_valid = 1'b0; in_sync = '0;
        @(negedge clk);
        chk("R8 valid not yet", int'(out_valid), 0);
        @(negedge clk);
        chk("R8 valid after 3", int'(out_valid), 1);
        chk("R8 sync after 3", int'(out_sync), int'(sb));
        chk({req, " comp0"}, int'(out_pix[7:0]), e0);
        chk({req, " comp1"}, int'(out_pix[15:8]), e1);
        chk({req, " comp2"}, int'(out_pix[23:16]), e2);
    endtask

    task automatic set_ctrl(input logic [31:0] c);
        wr(8'h40, c);
        strobe();
        swap_cfg = c[4];
        mat_cfg  = c[0] && c[3:2] == 2'd3;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 sync", int'(out_sync), 0);
        chk("R1 ycc", int'(out_ycc), 0);
        push(10, 20, 30, 2'b01, "R1 bypass after reset");
        for (int r = 0; r < 3; r++) set_row(r, 0, 0, 0, 0);
        set_ctrl(32'h0D);
        push(100, 50, 200, 2'b10, "R1 zero coefficients");
    endtask

    task automatic t_bypass();
        set_ctrl(32'h10);
        push(1, 2, 3, 2'b11, "R4 swap in bypass");
        set_ctrl(32'h05);
        push(1, 2, 3, 2'b00, "R3 mode 1 bypass");
        set_ctrl(32'h01);
        push(7, 8, 9, 2'b01, "R3 mode 0 bypass");
        set_ctrl(32'h0C);
        push(70, 80, 90, 2'b10, "R3 custom but disabled");
    endtask

    task automatic t_ycc();
        wr(8'h40, 32'h02);
        @(negedge clk);
        chk("R9 ycc before strobe", int'(out_ycc), 0);
        strobe();
        @(negedge clk);
        chk("R2 ycc active", int'(out_ycc), 1);
        swap_cfg = 1'b0; mat_cfg = 1'b0;
        push(5, 6, 7, 2'b00, "R2 flag is not arithmetic");
    endtask

    task automatic t_identity();
        set_row(0, 'h800, 0, 0, 0);
        set_row(1, 0, 'h800, 0, 0);
        set_row(2, 0, 0, 'h800, 0);
        write_matrix();
        set_ctrl(32'h0D);
        push(0, 128, 255, 2'b01, "R6 identity");
        push(17, 99, 3, 2'b10, "R6 identity");
        set_ctrl(32'h1D);
        push(17, 99, 3, 2'b11, "R4 swap in matrix mode");
    endtask

    task automatic t_layout();
        set_row(0, 'h800, 0, 0, 'h050);
        set_row(1, 0, 0, 'h400, 0);
        set_row(2, 'h200, 'h200, 0, 'h010);
        write_matrix();
        set_ctrl(32'h0D);
        push(40, 80, 120, 2'b00, "R5 coefficient layout");
        push(200, 10, 60, 2'b01, "R5 coefficient layout");
    endtask

    task automatic t_limited();
        set_row(0, 0, 0, 'h6E0, 'h100);
        set_row(1, 0, 'h6E0, 0, 'h100);
        set_row(2, 'h6E0, 0, 0, 'h100);
        write_matrix();
        set_ctrl(32'h0F);
        push(0, 0, 0, 2'b00, "R10 black");
        chk("R10 black level", int'(out_pix[7:0]), 16);
        push(255, 255, 255, 2'b01, "R10 white");
        chk("R10 white level", int'(out_pix[15:8]), 235);
        push(255, 0, 128, 2'b10, "R10 mixed");
    endtask

    task automatic t_round();
        set_row(0, 'h400, 0, 0, 0);
        set_row(1, 0, 0, 0, 'h8);
        set_row(2, 0, 0, 0, -8);
        write_matrix();
        set_ctrl(32'h0D);
        push(1, 0, 0, 2'b00, "R6 rounding half");
        chk("R6 half rounds up", int'(out_pix[7:0]), 1);
        push(3, 0, 0, 2'b01, "R6 rounding 1.5");
        chk("R6 1.5 rounds to 2", int'(out_pix[7:0]), 2);
    endtask

    task automatic t_sat();
        set_row(0, 'h1000, 0, 0, 0);
        set_row(1, 0, -'h800, 0, 0);
        set_row(2, 0, 0, 0, 'h7FFF);
        write_matrix();
        set_ctrl(32'h0D);
        push(200, 100, 0, 2'b11, "R7 clamp");
        chk("R7 high clamp", int'(out_pix[7:0]), 255);
        chk("R7 low clamp", int'(out_pix[15:8]), 0);
        push(100, 0, 0, 2'b00, "R7 in range");
    endtask

    task automatic t_shadow();
        set_row(0, 'h800, 0, 0, 0);
        set_row(1, 0, 'h800, 0, 0);
        set_row(2, 0, 0, 'h800, 0);
        write_matrix();
        set_ctrl(32'h0D);
        set_row(0, 0, 0, 'h6E0, 'h100);
        set_row(1, 0, 'h6E0, 0, 'h100);
        set_row(2, 'h6E0, 0, 0, 'h100);
        write_matrix();
        wr(8'h40, 32'h00);
        set_row(0, 'h800, 0, 0, 0);
        set_row(1, 0, 'h800, 0, 0);
        set_row(2, 0, 0, 'h800, 0);
        push(0, 200, 255, 2'b01, "R9 old setting kept");
        strobe();
        mat_cfg = 1'b0;
        push(0, 200, 255, 2'b10, "R9 new control after strobe");
        set_row(0, 0, 0, 'h6E0, 'h100);
        set_row(1, 0, 'h6E0, 0, 'h100);
        set_row(2, 'h6E0, 0, 0, 'h100);
        set_ctrl(32'h0D);
        push(0, 200, 255, 2'b11, "R9 new matrix after strobe");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_ycc();
        t_identity();
        t_layout();
        t_limited();
        t_round();
        t_sat();
        t_shadow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL R8: watchdog expired, actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule